// File: doc/BRIEF.md
# Gain-Compensating Float-to-Fixed Converter

This block sits between a two's-complement ADC sample stream and a wide decimating filter. Ahead of the ADC, a step-gain amplifier changes its analog gain in 6 dB steps under a 3-bit code. The converter treats that code as a floating-point exponent. It shifts each sample left by the bitwise complement of the code, so every doubling of analog gain is undone by halving the digital gain. A programmable scale shift then places the word inside the filter accumulator. The net digital gain is 2^(scale − 44 − code), measured relative to a full 51-bit shift.

An inhibit input removes the code from the shift, and the path then runs at a fixed digital gain. The amplifier code is delayed by a parameterized number of clock cycles. This delay matches the ADC conversion latency, so each sample is scaled by the code that was in force when that sample was taken. One output register and a valid strobe finish the path. The output word is wide enough to hold a full-scale sample at the largest total shift without overflow.

Top module: `ffx_gain_comp`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_word` is 0 until the first valid sample is registered.
- R2: `out_valid` equals `in_valid` delayed by one clock. When `in_valid` is 0, `out_word` keeps its previous value.
- R3: With `exp_inhibit` = 0, the registered result is the sign-extended sample multiplied by 2^(e + s). Here e = 7 − code, the bitwise complement of the 3-bit code, and s is the effective scale.
- R4: With `exp_inhibit` = 1, the code has no effect, and the result is the sample multiplied by 2^(7 + s).
- R5: The code applied to a sample presented at clock edge k is the `gain_code` value sampled at edge k − CODE_LAG (default 2). Codes from before reset release count as 0. `exp_inhibit` applies to the sample it arrives with.
- R6: The scale shift s equals `scale_shift` for values 0 to 44 inclusive.
- R7: A `scale_shift` value above 44 acts as 44.
- R8: The result keeps the sign of the sample for every shift. A full-scale sample of −2048 or +2047 at the largest total shift of 51 is represented exactly in the 63-bit output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| sample | input | 12 | Two's-complement ADC sample |
| gain_code | input | 3 | Code currently driving the step-gain amplifier |
| exp_inhibit | input | 1 | 1 = ignore the code in the shift |
| scale_shift | input | 6 | Extra left shift, 0 to 44 (saturated) |
| out_valid | output | 1 | Result strobe |
| out_word | output | 63 | Sign-extended, shifted fixed-point result |

## Verification
The hardest situation to produce is a code that changes on every clock while samples keep flowing. A wrong code-alignment depth only shows up when the code at edge k differs from the code at edges k − 1 and k − 2. The bench therefore steps the code on every cycle of its sweep, and it keeps its own history of past codes to predict the exponent. The sweep covers every code, both inhibit values, sign and full-scale samples, and scale values at 0, 44 and beyond 44. An extra run holds the sample constant while only the code changes. This isolates the lag.

// File: rtl/ffx_pkg.sv
package ffx_pkg;
   localparam int unsigned FFX_SAMPLE_W  = 12;
   localparam int unsigned FFX_CODE_W    = 3;
   localparam int unsigned FFX_SCALE_W   = 6;
   localparam int unsigned FFX_SCALE_MAX = 44;
   localparam int unsigned FFX_CODE_LAG  = 2;

   // largest exponent a code field of the given width can produce
   function automatic int unsigned ffx_exp_max(input int unsigned code_w);
      return (1 << code_w) - 1;
   endfunction
endpackage

// File: rtl/ffx_code_align.sv
module ffx_code_align #(
   parameter int unsigned CODE_W = 3,
   parameter int unsigned LAG    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_in,
   output logic [CODE_W-1:0] code_out
);
   generate
      if (LAG == 0) begin : g_direct
         assign code_out = code_in;
      end else begin : g_line
         logic [CODE_W-1:0] stage [LAG];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(LAG); i++) stage[i] <= '0;
            end else begin
               stage[0] <= code_in;
               for (int i = 1; i < int'(LAG); i++) stage[i] <= stage[i-1];
            end
         end
         assign code_out = stage[LAG-1];
      end
   endgenerate
endmodule

// File: rtl/ffx_exp_shift.sv
module ffx_exp_shift #(
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned CODE_W   = 3,
   parameter int unsigned FX_W     = 19
) (
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [CODE_W-1:0]   code,
   input  logic                inhibit,
   output logic [FX_W-1:0]     fx_word
);
   logic [CODE_W-1:0]      expo;
   logic signed [FX_W-1:0] widened;

   // complement of the gain code; inhibit pins it to the all-ones exponent
   assign expo    = inhibit ? '1 : ~code;
   assign widened = FX_W'($signed(sample));
   assign fx_word = widened <<< expo;
endmodule

// File: rtl/ffx_scale_shift.sv
module ffx_scale_shift #(
   parameter int unsigned FX_W      = 19,
   parameter int unsigned SCALE_W   = 6,
   parameter int unsigned SCALE_MAX = 44,
   parameter int unsigned OUT_W     = 63
) (
   input  logic [FX_W-1:0]    fx_word,
   input  logic [SCALE_W-1:0] scale,
   output logic [OUT_W-1:0]   out_word
);
   localparam logic [SCALE_W-1:0] LIMIT = SCALE_W'(SCALE_MAX);

   logic [SCALE_W-1:0]      eff_scale;
   logic signed [OUT_W-1:0] widened;

   assign eff_scale = (scale > LIMIT) ? LIMIT : scale;
   assign widened   = OUT_W'($signed(fx_word));
   assign out_word  = widened <<< eff_scale;
endmodule

// File: rtl/ffx_gain_comp.sv
module ffx_gain_comp
   import ffx_pkg::*;
#(
   parameter int unsigned SAMPLE_W  = FFX_SAMPLE_W,
   parameter int unsigned CODE_W    = FFX_CODE_W,
   parameter int unsigned SCALE_W   = FFX_SCALE_W,
   parameter int unsigned SCALE_MAX = FFX_SCALE_MAX,
   parameter int unsigned CODE_LAG  = FFX_CODE_LAG,
   localparam int unsigned EXP_MAX  = ffx_exp_max(CODE_W),
   localparam int unsigned FX_W     = SAMPLE_W + EXP_MAX,
   localparam int unsigned OUT_W    = FX_W + SCALE_MAX
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [CODE_W-1:0]   gain_code,
   input  logic                exp_inhibit,
   input  logic [SCALE_W-1:0]  scale_shift,
   output logic                out_valid,
   output logic [OUT_W-1:0]    out_word
);
   generate
      if (SAMPLE_W < 2) begin : g_bad_sample
         $error("SAMPLE_W must be at least 2");
      end
      if (CODE_W < 1 || CODE_W > 4) begin : g_bad_code
         $error("CODE_W must be 1 to 4");
      end
      if (SCALE_MAX > (1 << SCALE_W) - 1) begin : g_bad_scale
         $error("SCALE_MAX does not fit in SCALE_W");
      end
   endgenerate

   logic [CODE_W-1:0] code_aligned;
   logic [FX_W-1:0]   fx_word;
   logic [OUT_W-1:0]  shifted;

   ffx_code_align #(.CODE_W(CODE_W), .LAG(CODE_LAG)) u_align (
      .clk      (clk),
      .rst_n    (rst_n),
      .code_in  (gain_code),
      .code_out (code_aligned)
   );

   ffx_exp_shift #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .FX_W(FX_W)) u_exp (
      .sample  (sample),
      .code    (code_aligned),
      .inhibit (exp_inhibit),
      .fx_word (fx_word)
   );

   ffx_scale_shift #(.FX_W(FX_W), .SCALE_W(SCALE_W), .SCALE_MAX(SCALE_MAX),
                     .OUT_W(OUT_W)) u_scale (
      .fx_word  (fx_word),
      .scale    (scale_shift),
      .out_word (shifted)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_word <= shifted;
      end
   end
endmodule

// File: rtl/ffx_gain_comp_chk.sv
module ffx_gain_comp_chk #(
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned SCALE_W  = 6,
   parameter int unsigned OUT_W    = 63
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic [SAMPLE_W-1:0] sample,
   input logic                exp_inhibit,
   input logic [SCALE_W-1:0]  scale_shift,
   input logic                out_valid,
   input logic [OUT_W-1:0]    out_word
);
   localparam logic [OUT_W-1:0] INH_ZERO_SCALE_SEXT = '0;

   // R2: strobe follows one cycle later
   p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_word));
   // R8: sign survives every shift
   p_sign_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sample != '0) |=> (out_word[OUT_W-1] == $past(sample[SAMPLE_W-1])));
   // R3: zero input gives zero output regardless of shift
   p_zero_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sample == '0) |=> (out_word == INH_ZERO_SCALE_SEXT));
   // R4: inhibited, unscaled path applies exactly a 7-bit shift
   p_inhibit_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && exp_inhibit && scale_shift == '0) |=>
      (out_word == (OUT_W'($signed($past(sample))) <<< 7)));
endmodule

bind ffx_gain_comp ffx_gain_comp_chk #(
   .SAMPLE_W (SAMPLE_W),
   .SCALE_W  (SCALE_W),
   .OUT_W    (OUT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .sample      (sample),
   .exp_inhibit (exp_inhibit),
   .scale_shift (scale_shift),
   .out_valid   (out_valid),
   .out_word    (out_word)
);

// File: tb/ffx_gain_comp_tb.sv
module ffx_gain_comp_tb;
   localparam int LAG = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [11:0] sample = '0;
   logic [2:0]  gain_code = '0;
   logic        exp_inhibit = 1'b0;
   logic [5:0]  scale_shift = '0;
   logic        out_valid;
   logic [62:0] out_word;

   int checks = 0;
   int errors = 0;
   int hist [LAG];
   longint exp_word = 0;
   bit done = 0;

   always #10 clk = ~clk;

   ffx_gain_comp u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sample(sample),
      .gain_code(gain_code), .exp_inhibit(exp_inhibit), .scale_shift(scale_shift),
      .out_valid(out_valid), .out_word(out_word)
   );

   task automatic check(input string req, input longint act, input longint expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // drive one cycle, model the expected result, check after the edge
   task automatic cyc(input bit v, input int s, input int c, input bit inh,
                      input int sc, input string req);
      int lagged;
      int eff;
      int sh;
      @(negedge clk);
      in_valid = v; sample = 12'(s); gain_code = 3'(c);
      exp_inhibit = inh; scale_shift = 6'(sc);
      @(posedge clk);
      lagged = hist[LAG-1];
      for (int i = LAG-1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = c;
      eff = (sc > 44) ? 44 : sc;
      sh = (inh ? 7 : 7 - lagged) + eff;
      if (v) exp_word = longint'($signed(12'(s))) <<< sh;
      #2;
      check({req, " valid"}, longint'(out_valid), longint'(v));
      check(req, longint'($signed(out_word)), exp_word);
   endtask

   initial begin
      for (int i = 0; i < LAG; i++) hist[i] = 0;
      repeat (3) @(posedge clk);
      #2;
      check("R1 reset valid", longint'(out_valid), 0);
      check("R1 reset word", longint'($signed(out_word)), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      for (int i = LAG-1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = 0;
      #2;
      check("R1 after release", longint'($signed(out_word)), 0);

      // R3 R4 R6 R7 R8 sweep: code steps every cycle
      begin
         int samples [8] = '{-2048, -1, 0, 1, 2047, -1365, 683, 5};
         int scales  [6] = '{0, 1, 13, 44, 45, 63};
         int n = 0;
         for (int sc = 0; sc < 6; sc++)
            for (int inh = 0; inh < 2; inh++)
               for (int si = 0; si < 8; si++)
                  for (int c = 0; c < 8; c++) begin
                     n++;
                     cyc(1'b1, samples[si], (c + si + n) % 8, inh[0], scales[sc],
                         inh ? "R4/R6/R7/R8 inhibited" : "R3/R6/R7/R8 exponent");
                  end
      end

      // R5: constant sample, code moves alone
      for (int k = 0; k < 16; k++)
         cyc(1'b1, 100, (k * 3) % 8, 1'b0, 0, "R5 code lag");

      // R2: idle cycles with changing inputs must hold the word
      for (int k = 0; k < 6; k++)
         cyc(1'b0, 1234 - k, k, 1'b0, k * 9, "R2 hold when idle");

      // R8: extreme corners at full shift
      cyc(1'b1, -2048, 0, 1'b0, 44, "R8 neg full scale");
      cyc(1'b1, 0, 0, 1'b0, 44, "R8 setup");
      cyc(1'b1, 2047, 0, 1'b0, 44, "R8 pos full scale");
      cyc(1'b1, -2048, 7, 1'b1, 63, "R8 inhibited max R7");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule